// File: doc/BRIEF.md
# Serial Slave Front End with Pause Control

This block is the serial-side front end of a register-controlled device. It watches an active-low select, a serial clock and a data line. It turns the incoming bit stream into bytes for a register controller. It can also shift a byte from the controller back out on a three-state data line. All serial inputs are brought into the system clock domain through two-flop synchronizers, and the serial clock is oversampled there. Edges are therefore detected as single-cycle pulses, and the serial clock must run well below the system clock.

Every frame opens with an address byte. Its upper bits must carry a fixed device-type code and its lowest two bits must equal the two strap inputs. A matching frame is announced with a start strobe, and every later byte is delivered with a valid strobe. A frame that does not match is ignored until the select is released. A pause input, changed only while the serial clock is low, freezes a transfer at the current bit, and the transfer continues from that bit when the input is released. After reset, no frame is accepted until the select has fallen from high to low.

Top module: `spi_hold_slave`

## Requirements
- R1: Data bits are sampled on the rising serial clock edge, most significant bit first; every completed byte after the address byte appears on `rx_byte_o` with a one-cycle `rx_valid_o` pulse.
- R2: The address byte is accepted when bits [7:2] equal `DEV_CODE` (default 6'b010100) and bits [1:0] equal `strap_i`. Acceptance gives a one-cycle `frame_start_o` pulse, and the address byte itself produces no `rx_valid_o`.
- R3: After an address byte that does not match, the rest of the frame produces no `rx_valid_o`, no `frame_start_o`, no `frame_end_o`, and `sdo_oe_o` stays low.
- R4: `tx_byte_i` is captured on the clock edge where `frame_start_o` or `rx_valid_o` rises, provided `tx_valid_i` is high then. It is shifted out during the next byte, most significant bit first, with each bit changing on a falling serial clock edge, and `sdo_oe_o` stays high for that whole byte.
- R5: `sdo_oe_o` is low whenever no captured byte is being shifted out, and it goes low at once when `cs_ni` goes high.
- R6: Pulling `hold_ni` low while the serial clock is low pauses the frame, and serial clock edges are ignored while it is paused. Raising `hold_ni` while the serial clock is low resumes the frame at the same bit.
- R7: Raising `cs_ni` clears the frame: a partly received byte is discarded, and the next frame starts again with an address byte.
- R8: After reset, no byte is accepted until `cs_ni` has made a high-to-low transition. A select held low through reset opens no frame.
- R9: `frame_end_o` pulses once, for one cycle, when `cs_ni` rises after an accepted address byte.
- R10: The three strobes are one cycle wide and never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select |
| sck_i | input | 1 | Serial clock, idles low |
| sdi_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Active-low pause |
| strap_i | input | STRAP_W | Static address straps |
| tx_byte_i | input | BYTE_W | Byte to shift out next |
| tx_valid_i | input | 1 | `tx_byte_i` should be sent |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for `sdo_o` |
| rx_byte_o | output | BYTE_W | Last received data byte |
| rx_valid_o | output | 1 | `rx_byte_o` updated |
| frame_start_o | output | 1 | Address byte matched |
| frame_end_o | output | 1 | Accepted frame closed |

## Verification
A bit counter that drifts by one shifts every later byte of the frame. That shows at the ports within the next byte, either as a wrong `rx_byte_o` or as a `rx_valid_o` pulse that is missing or comes early. A pause flag that is wrong lets the garbage clocks sent during a pause into the data byte, so the byte delivered after the resume is corrupted. A frame state that survives a select release, or that opens without a falling edge, shows up as strobes or an enabled output in a frame that should have been silent. The tests are ordered so that each of these faults changes a strobe count or a byte value that is checked within the same frame.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } frame_st_e;
endpackage

// File: rtl/spi_sync_bank.sv
module spi_sync_bank #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_clk_ctrl.sv
module spi_clk_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic hold_ni,
  input  logic open_i,
  output logic rise_o,
  output logic fall_o,
  output logic paused_o
);
  logic sck_prev_q;
  logic paused_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_prev_q <= 1'b0;
      paused_q   <= 1'b0;
    end else begin
      sck_prev_q <= sck_i;
      if (!open_i)     paused_q <= 1'b0;
      else if (!sck_i) paused_q <= !hold_ni; // pause state changes only with clock low
    end
  end

  assign rise_o   = open_i && !paused_q && sck_i && !sck_prev_q;
  assign fall_o   = open_i && !paused_q && !sck_i && sck_prev_q;
  assign paused_o = paused_q;

  // R6: a pause never begins while the serial clock is high
  p_pause_entry_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!paused_q && open_i && sck_i) |=> !paused_q);
endmodule

// File: rtl/spi_rx_deser.sv
module spi_rx_deser #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rise_i,
  input  logic              bit_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              done_o
);
  localparam logic [CNT_W-1:0] CntLast = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q, byte_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;
  logic [BYTE_W-1:0] sh_next;

  assign sh_next = {sh_q[BYTE_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      byte_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (rise_i) begin
        sh_q <= sh_next;
        if (cnt_q == CntLast) begin
          cnt_q  <= '0;
          byte_q <= sh_next;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign byte_o = byte_q;
  assign done_o = done_q;

  // R10: byte completion is a single-cycle event
  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R7: a cleared frame starts counting from bit zero
  p_clr_restarts_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && cnt_q != '0) |=> (cnt_q == '0) && !done_q);
endmodule

// File: rtl/spi_tx_ser.sv
module spi_tx_ser #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic              en_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              fall_i,
  output logic              sdo_o,
  output logic              active_o
);
  logic [BYTE_W-1:0] sh_q;
  logic              sdo_q;
  logic              active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      sdo_q    <= 1'b0;
      active_q <= 1'b0;
    end else if (clr_i) begin
      active_q <= 1'b0;
    end else if (load_i) begin
      sh_q     <= data_i;
      active_q <= en_i;
    end else if (fall_i) begin
      sdo_q <= sh_q[BYTE_W-1];
      sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
    end
  end

  assign sdo_o    = sdo_q;
  assign active_o = active_q;

  // R5: a cleared frame never keeps driving
  p_clr_drops_drive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !active_q);
endmodule

// File: rtl/spi_hold_slave.sv
module spi_hold_slave
  import spi_hold_pkg::*;
#(
  parameter int                       BYTE_W      = 8,
  parameter int                       STRAP_W     = 2,
  parameter int                       SYNC_STAGES = 2,
  parameter logic [BYTE_W-STRAP_W-1:0] DEV_CODE   = 6'b010100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               sck_i,
  input  logic               sdi_i,
  input  logic               hold_ni,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [BYTE_W-1:0]  tx_byte_i,
  input  logic               tx_valid_i,
  output logic               sdo_o,
  output logic               sdo_oe_o,
  output logic [BYTE_W-1:0]  rx_byte_o,
  output logic               rx_valid_o,
  output logic               frame_start_o,
  output logic               frame_end_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic cs_s, sck_s, sdi_s, hold_n_s;
  logic cs_prev_q, cs_fall;
  logic frame_open, frame_clr;
  logic sck_rise, sck_fall, paused;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_byte;
  logic              rx_done;
  logic              addr_match;
  logic              tx_load, tx_active;

  frame_st_e         state_q, state_d;
  logic              valid_q, valid_d;
  logic              start_q, start_d;
  logic              end_q, end_d;
  logic [BYTE_W-1:0] byte_q;

  spi_sync_bank #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, sdi_i, hold_ni}),
    .q_o   ({cs_s, sck_s, sdi_s, hold_n_s})
  );

  // previous select resets low so a select held low through reset is no edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_prev_q <= 1'b0;
    else         cs_prev_q <= cs_s;
  end
  assign cs_fall    = cs_prev_q && !cs_s;
  assign frame_open = (state_q != ST_IDLE) && !cs_s;
  assign frame_clr  = !frame_open;

  spi_clk_ctrl u_clk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sck_i   (sck_s),
    .hold_ni (hold_n_s),
    .open_i  (frame_open),
    .rise_o  (sck_rise),
    .fall_o  (sck_fall),
    .paused_o(paused)
  );

  spi_rx_deser #(.BYTE_W(BYTE_W)) u_rx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (frame_clr),
    .rise_i(sck_rise),
    .bit_i (sdi_s),
    .cnt_o (bit_cnt),
    .byte_o(rx_byte),
    .done_o(rx_done)
  );

  assign addr_match = (rx_byte[BYTE_W-1:STRAP_W] == DEV_CODE) &&
                      (rx_byte[STRAP_W-1:0] == strap_i);

  always_comb begin
    state_d = state_q;
    valid_d = 1'b0;
    start_d = 1'b0;
    end_d   = 1'b0;
    tx_load = 1'b0;
    if (cs_s) begin
      state_d = ST_IDLE;
      end_d   = (state_q == ST_DATA);
    end else begin
      unique case (state_q)
        ST_IDLE: if (cs_fall) state_d = ST_ADDR;
        ST_ADDR: if (rx_done) begin
          if (addr_match) begin
            state_d = ST_DATA;
            start_d = 1'b1;
            tx_load = 1'b1;
          end else begin
            state_d = ST_SKIP;
          end
        end
        ST_DATA: if (rx_done) begin
          valid_d = 1'b1;
          tx_load = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      valid_q <= 1'b0;
      start_q <= 1'b0;
      end_q   <= 1'b0;
      byte_q  <= '0;
    end else begin
      state_q <= state_d;
      valid_q <= valid_d;
      start_q <= start_d;
      end_q   <= end_d;
      if (valid_d) byte_q <= rx_byte;
    end
  end

  spi_tx_ser #(.BYTE_W(BYTE_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (frame_clr),
    .load_i  (tx_load),
    .en_i    (tx_valid_i),
    .data_i  (tx_byte_i),
    .fall_i  (sck_fall),
    .sdo_o   (sdo_o),
    .active_o(tx_active)
  );

  // raw select gates the enable so release is immediate
  assign sdo_oe_o      = tx_active && !cs_ni;
  assign rx_byte_o     = byte_q;
  assign rx_valid_o    = valid_q;
  assign frame_start_o = start_q;
  assign frame_end_o   = end_q;

  p_strobe_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({valid_q, start_q, end_q}));
  p_valid_in_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (state_q == ST_DATA));
  p_pause_freeze_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paused && frame_open) |=> $stable(bit_cnt));
  p_open_needs_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !cs_fall) |=> (state_q == ST_IDLE));
  p_end_once_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_q |=> !end_q);
endmodule

// File: tb/spi_hold_slave_tb_top.sv
module spi_hold_slave_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b0;
  logic       sck_i = 1'b0;
  logic       sdi_i = 1'b0;
  logic       hold_ni = 1'b1;
  logic [1:0] strap_i = 2'b01;
  logic [7:0] tx_byte_i = '0;
  logic       tx_valid_i = 1'b0;
  logic       sdo_o, sdo_oe_o, rx_valid_o, frame_start_o, frame_end_o;
  logic [7:0] rx_byte_o;

  always #10 clk_i = ~clk_i;

  spi_hold_slave dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck_i), .sdi_i(sdi_i),
    .hold_ni(hold_ni), .strap_i(strap_i), .tx_byte_i(tx_byte_i), .tx_valid_i(tx_valid_i),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .rx_byte_o(rx_byte_o), .rx_valid_o(rx_valid_o),
    .frame_start_o(frame_start_o), .frame_end_o(frame_end_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // strobe monitor
  int n_valid = 0, n_start = 0, n_end = 0, n_bad = 0;
  logic [7:0] log_q [16];
  logic pv = 1'b0, ps = 1'b0, pe = 1'b0;
  always @(posedge clk_i) begin
    if (rst_ni) begin
      if (rx_valid_o) begin
        log_q[n_valid % 16] <= rx_byte_o;
        n_valid <= n_valid + 1;
      end
      if (frame_start_o) n_start <= n_start + 1;
      if (frame_end_o)   n_end <= n_end + 1;
      if (($countones({rx_valid_o, frame_start_o, frame_end_o}) > 1) ||
          (rx_valid_o && pv) || (frame_start_o && ps) || (frame_end_o && pe))
        n_bad <= n_bad + 1;
      pv <= rx_valid_o; ps <= frame_start_o; pe <= frame_end_o;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send_bit(input logic b, output logic so, output logic oe);
    sdi_i = b;
    wait_clk(5);
    so = sdo_o;
    oe = sdo_oe_o;
    sck_i = 1'b1;
    wait_clk(5);
    sck_i = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] d, output logic [7:0] so, output logic [7:0] oe);
    for (int i = 7; i >= 0; i--) send_bit(d[i], so[i], oe[i]);
  endtask

  task automatic open_frame();
    cs_ni = 1'b0;
    wait_clk(4);
  endtask

  task automatic close_frame();
    cs_ni = 1'b1;
    wait_clk(6);
  endtask

  task automatic t_reset();
    chk(sdo_oe_o == 1'b0, "R5 reset oe", sdo_oe_o, 0);
    chk({rx_valid_o, frame_start_o, frame_end_o} == 3'b000, "R10 reset strobes",
        {rx_valid_o, frame_start_o, frame_end_o}, 0);
  endtask

  task automatic t_unarmed();
    logic [7:0] so, oe;
    int s0 = n_start, v0 = n_valid, e0 = n_end;
    xfer(8'h51, so, oe);
    xfer(8'hAA, so, oe);
    chk(n_start == s0, "R8 no start before select fall", n_start - s0, 0);
    chk(n_valid == v0, "R8 no byte before select fall", n_valid - v0, 0);
    close_frame();
    chk(n_end == e0, "R8 no end for unopened frame", n_end - e0, 0);
  endtask

  task automatic t_write();
    logic [7:0] so, oe;
    int s0 = n_start, v0 = n_valid, e0 = n_end;
    open_frame();
    xfer(8'h51, so, oe);
    chk(n_start == s0 + 1, "R2 start on match", n_start - s0, 1);
    chk(n_valid == v0, "R2 address not delivered", n_valid - v0, 0);
    xfer(8'hA5, so, oe);
    xfer(8'h3C, so, oe);
    chk(n_valid == v0 + 2, "R1 two bytes valid", n_valid - v0, 2);
    chk(log_q[v0 % 16] == 8'hA5, "R1 first byte", log_q[v0 % 16], 8'hA5);
    chk(log_q[(v0 + 1) % 16] == 8'h3C, "R1 second byte", log_q[(v0 + 1) % 16], 8'h3C);
    chk(oe == 8'h00, "R5 no drive without tx_valid", oe, 0);
    close_frame();
    chk(n_end == e0 + 1, "R9 one end pulse", n_end - e0, 1);
  endtask

  task automatic t_read();
    logic [7:0] so, oe;
    tx_byte_i = 8'hC6;
    tx_valid_i = 1'b1;
    open_frame();
    xfer(8'h51, so, oe);
    chk(oe == 8'h00, "R5 no drive during address", oe, 0);
    tx_valid_i = 1'b0;
    tx_byte_i = 8'h00;
    xfer(8'h12, so, oe);
    chk(so == 8'hC6, "R4 read data msb first", so, 8'hC6);
    chk(oe == 8'hFF, "R4 drive whole byte", oe, 8'hFF);
    xfer(8'h34, so, oe);
    chk(oe == 8'h00, "R5 released when nothing loaded", oe, 0);
    close_frame();
  endtask

  task automatic t_reject();
    logic [7:0] so, oe;
    int s0 = n_start, v0 = n_valid, e0 = n_end;
    strap_i = 2'b10;
    tx_byte_i = 8'hFF;
    tx_valid_i = 1'b1;
    open_frame();
    xfer(8'h51, so, oe);
    xfer(8'h77, so, oe);
    chk(oe == 8'h00, "R3 no drive after strap mismatch", oe, 0);
    xfer(8'h78, so, oe);
    close_frame();
    chk(n_start == s0 && n_valid == v0 && n_end == e0, "R3 strap mismatch silent",
        (n_start - s0) + (n_valid - v0) + (n_end - e0), 0);
    strap_i = 2'b01;
    open_frame();
    xfer(8'h91, so, oe);
    xfer(8'h66, so, oe);
    close_frame();
    chk(n_start == s0 && n_valid == v0, "R3 device code mismatch silent",
        (n_start - s0) + (n_valid - v0), 0);
    tx_valid_i = 1'b0;
  endtask

  task automatic t_hold();
    logic [7:0] so, oe;
    logic s1, o1;
    int v0 = n_valid;
    open_frame();
    xfer(8'h51, so, oe);
    for (int i = 7; i >= 4; i--) send_bit(8'h9E >> i, s1, o1);
    hold_ni = 1'b0;
    wait_clk(5);
    sdi_i = 1'b1;
    for (int k = 0; k < 6; k++) begin
      sck_i = 1'b1; wait_clk(5);
      sck_i = 1'b0; wait_clk(5);
    end
    chk(n_valid == v0, "R6 paused clocks ignored", n_valid - v0, 0);
    hold_ni = 1'b1;
    wait_clk(5);
    for (int i = 3; i >= 0; i--) send_bit(8'h9E >> i, s1, o1);
    chk(n_valid == v0 + 1, "R6 byte after resume", n_valid - v0, 1);
    chk(log_q[v0 % 16] == 8'h9E, "R6 resumed at same bit", log_q[v0 % 16], 8'h9E);
    close_frame();
  endtask

  task automatic t_abort();
    logic [7:0] so, oe;
    logic s1, o1;
    int s0 = n_start, v0 = n_valid, e0 = n_end;
    open_frame();
    for (int i = 7; i >= 5; i--) send_bit(8'h51 >> i, s1, o1);
    close_frame();
    chk(n_end == e0, "R9 no end before acceptance", n_end - e0, 0);
    open_frame();
    xfer(8'h51, so, oe);
    for (int i = 7; i >= 4; i--) send_bit(8'hFF >> i, s1, o1);
    close_frame();
    chk(n_valid == v0, "R7 partial byte discarded", n_valid - v0, 0);
    chk(n_end == e0 + 1, "R9 end after abort", n_end - e0, 1);
    open_frame();
    xfer(8'h51, so, oe);
    xfer(8'h5A, so, oe);
    close_frame();
    chk(n_start == s0 + 2, "R7 fresh frame start", n_start - s0, 2);
    chk(log_q[v0 % 16] == 8'h5A, "R7 clean byte after abort", log_q[v0 % 16], 8'h5A);
  endtask

  task automatic t_cs_oe();
    logic [7:0] so, oe;
    logic s1, o1;
    tx_byte_i = 8'hFF;
    tx_valid_i = 1'b1;
    open_frame();
    xfer(8'h51, so, oe);
    for (int k = 0; k < 3; k++) send_bit(1'b0, s1, o1);
    chk(sdo_oe_o == 1'b1, "R4 driving mid byte", sdo_oe_o, 1);
    cs_ni = 1'b1;
    #1;
    chk(sdo_oe_o == 1'b0, "R5 select release drops drive", sdo_oe_o, 0);
    wait_clk(6);
    tx_valid_i = 1'b0;
  endtask

  initial begin
    wait_clk(5);
    rst_ni = 1'b1;
    wait_clk(3);
    t_reset();
    t_unarmed();
    t_write();
    t_read();
    t_reject();
    t_hold();
    t_abort();
    t_cs_oe();
    chk(n_bad == 0, "R10 strobe width and overlap", n_bad, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule